// File: doc/BRIEF.md
# Burst Shared Memory Port

This block lets a bus master reach a word-addressed shared data RAM through a small I/O register window instead of presenting a memory address for every word. The master first writes a start address to a dedicated pointer-load port. Each later read or write on the data port then moves one word at the current pointer value. When that access strobe ends, the pointer advances by one. A third port reads the pointer back, so software can check where a burst has reached.

The RAM is a synchronous array inside the block. Its width is the full data bus, which carries no address. Arbitration between masters and wait-state generation sit outside the block. The I/O strobe `io_sel` marks one access for as long as it stays high, whatever that length is. The port number and direction are taken on the first cycle of the strobe.

Top module: `bmp_port`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the pointer to zero. `io_rdata` reads zero in the cycle after a reset edge.
- R2: A write access to the pointer-load port (`io_addr` = 0) loads the pointer with the low `ADDR_W` bits of `io_wdata`. The new value is taken on the first strobe cycle.
- R3: A write access to the data port (`io_addr` = 1) stores `io_wdata` into the RAM word that the pointer selects.
- R4: A read access to the data port returns the word at the pointer value from before the advance. The word appears on `io_rdata` from the cycle after the strobe first goes high, and stays there while the strobe is held.
- R5: Each data-port access, read or write, advances the pointer by exactly one, however many cycles the strobe lasts. The new value shows from the cycle after the strobe falls.
- R6: Advancing from the all-ones pointer value wraps the pointer to zero.
- R7: A read access to the readback port (`io_addr` = 2) returns the pointer, zero-extended, on `io_rdata`.
- R8: These accesses change neither the pointer nor the RAM: a write to the readback port, a read of the pointer-load port, and any access to port 3. Their reads return zero.
- R9: After any clock edge at which no read strobe is present, `io_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_sel | input | 1 | Access strobe; high for the whole of one access |
| io_wr | input | 1 | 1 = write access, 0 = read access |
| io_addr | input | IO_AW | I/O port number: 0 pointer load, 1 data, 2 pointer readback |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Read data, registered; zero when no read is in progress |

## Verification
The bench builds the block with `ADDR_W` = 6, which gives a 64-word RAM. A single fill burst therefore runs through every location and wraps the pointer back to zero. Reads that start at 62 can then cross the all-ones boundary within a few accesses. `DATA_W` stays at 16 and `IO_AW` stays at 2, so all four port codes can be exercised, including the unmapped one. Strobe lengths vary from one to four cycles, which shows that a held strobe still counts as one access.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
    typedef enum logic [1:0] {
        PK_LOAD = 2'd0,
        PK_DATA = 2'd1,
        PK_VIEW = 2'd2,
        PK_NONE = 2'd3
    } port_kind_e;
endpackage

// File: rtl/bmp_decode.sv
module bmp_decode
    import bmp_pkg::*;
#(
    parameter int IO_AW     = 2,
    parameter int LOAD_PORT = 0,
    parameter int DATA_PORT = 1,
    parameter int VIEW_PORT = 2
) (
    input  logic [IO_AW-1:0] io_addr,
    output port_kind_e       kind
);
    always_comb begin
        if (io_addr == IO_AW'(LOAD_PORT))      kind = PK_LOAD;
        else if (io_addr == IO_AW'(DATA_PORT)) kind = PK_DATA;
        else if (io_addr == IO_AW'(VIEW_PORT)) kind = PK_VIEW;
        else                                   kind = PK_NONE;
    end
endmodule

// File: rtl/bmp_pointer.sv
module bmp_pointer
    import bmp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_sel,
    input  logic              io_wr,
    input  port_kind_e        kind,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr,
    output logic              ram_we
);
    typedef struct packed {
        logic              sel;
        port_kind_e        kind;
        logic [ADDR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic strobe_start, strobe_end;

    always_comb begin
        st_d         = st_q;
        strobe_start = io_sel && !st_q.sel;
        strobe_end   = !io_sel && st_q.sel;
        st_d.sel     = io_sel;
        if (strobe_start) begin
            st_d.kind = kind;
            if (kind == PK_LOAD && io_wr) st_d.ptr = load_val;
        end else if (strobe_end && st_q.kind == PK_DATA) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sel  <= 1'b0;
            st_q.kind <= PK_NONE;
            st_q.ptr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr    = st_q.ptr;
    assign ram_we = strobe_start && kind == PK_DATA && io_wr;

    // R2: a load write takes the written value
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (io_sel && !st_q.sel && kind == PK_LOAD && io_wr) |=> (ptr == $past(load_val)));

    // R5 / R6: a finished data access advances by one, modulo the depth
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (!io_sel && st_q.sel && st_q.kind == PK_DATA) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    // R8: nothing else moves the pointer
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!(io_sel && !st_q.sel && kind == PK_LOAD && io_wr) &&
         !(!io_sel && st_q.sel && st_q.kind == PK_DATA)) |=> $stable(ptr));
endmodule

// File: rtl/bmp_ram.sv
module bmp_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/bmp_port.sv
module bmp_port
    import bmp_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 16,
    parameter int IO_AW     = 2,
    parameter int LOAD_PORT = 0,
    parameter int DATA_PORT = 1,
    parameter int VIEW_PORT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_sel,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata
);
    localparam int LOAD_W = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;

    typedef struct packed {
        port_kind_e        kind;
        logic [ADDR_W-1:0] ptr;
    } out_state_t;

    port_kind_e        kind;
    logic [ADDR_W-1:0] ptr;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rd;
    logic [ADDR_W-1:0] load_val;
    out_state_t        out_d, out_q;

    assign load_val = ADDR_W'(io_wdata[LOAD_W-1:0]);

    bmp_decode #(
        .IO_AW(IO_AW), .LOAD_PORT(LOAD_PORT),
        .DATA_PORT(DATA_PORT), .VIEW_PORT(VIEW_PORT)
    ) i_decode (
        .io_addr(io_addr),
        .kind   (kind)
    );

    bmp_pointer #(.ADDR_W(ADDR_W)) i_pointer (
        .clk     (clk),
        .rst     (rst),
        .io_sel  (io_sel),
        .io_wr   (io_wr),
        .kind    (kind),
        .load_val(load_val),
        .ptr     (ptr),
        .ram_we  (ram_we)
    );

    bmp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (ptr),
        .wdata(io_wdata),
        .rdata(ram_rd)
    );

    always_comb begin
        out_d.ptr  = ptr;
        out_d.kind = PK_NONE;
        if (io_sel && !io_wr && (kind == PK_DATA || kind == PK_VIEW))
            out_d.kind = kind;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.kind <= PK_NONE;
            out_q.ptr  <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        case (out_q.kind)
            PK_DATA: io_rdata = ram_rd;
            PK_VIEW: io_rdata = DATA_W'(out_q.ptr);
            default: io_rdata = '0;
        endcase
    end

    // R1: output cleared after a reset edge
    a_r1_reset_out: assert property (@(posedge clk)
        rst |=> (io_rdata == '0));

    // R9: no read strobe, no read data
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !io_sel |=> (io_rdata == '0));

    // R7: readback shows the pointer of the sampling edge
    a_r7_view: assert property (@(posedge clk) disable iff (rst)
        (io_sel && !io_wr && kind == PK_VIEW) |=> (io_rdata == DATA_W'($past(ptr))));
endmodule

// File: tb/test_bmp_port.sv
module test_bmp_port;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          io_sel = 1'b0;
    logic          io_wr = 1'b0;
    logic [1:0]    io_addr = '0;
    logic [DW-1:0] io_wdata = '0;
    logic [DW-1:0] io_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bmp_port #(.ADDR_W(AW), .DATA_W(DW), .IO_AW(2)) i_bmp_port (
        .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_ok  [DEPTH];
    int            m_ptr = 0;
    bit            m_sel = 0;
    int            m_kind = 3;
    logic [DW-1:0] m_exp = '0;
    bit            m_exp_ok = 0;
    string         m_tag = "R1";

    initial for (int i = 0; i < DEPTH; i++) m_ok[i] = 0;

    always @(posedge clk) begin
        int nk;
        if (rst) begin
            m_ptr = 0; m_sel = 0; m_kind = 3;
            m_exp = '0; m_exp_ok = 1; m_tag = "R1";
        end else begin
            nk = int'(io_addr);
            m_exp_ok = 1;
            if (io_sel && !io_wr) begin
                if (nk == 1) begin
                    m_exp = m_mem[m_ptr]; m_exp_ok = m_ok[m_ptr]; m_tag = "R4";
                end else if (nk == 2) begin
                    m_exp = DW'(m_ptr); m_tag = "R7";
                end else begin
                    m_exp = '0; m_tag = "R8";
                end
            end else begin
                m_exp = '0; m_tag = "R9";
            end
            if (io_sel && !m_sel) begin
                m_kind = nk;
                if (nk == 0 && io_wr) m_ptr = int'(io_wdata) % DEPTH;
                if (nk == 1 && io_wr) begin
                    m_mem[m_ptr] = io_wdata; m_ok[m_ptr] = 1;
                end
            end else if (!io_sel && m_sel && m_kind == 1) begin
                m_ptr = (m_ptr + 1) % DEPTH;
            end
            m_sel = io_sel;
        end
    end

    always @(negedge clk) begin
        if (!done && m_exp_ok) begin
            n_checks++;
            if (io_rdata !== m_exp) begin
                n_fail++;
                $display("FAIL %s cycle compare: io_rdata=%h expected %h", m_tag, io_rdata, m_exp);
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic access(input logic [1:0] port, input logic wr, input logic [DW-1:0] wd,
                          input int hold, output logic [DW-1:0] rd);
        io_sel = 1'b1; io_addr = port; io_wr = wr; io_wdata = wd;
        repeat (hold) @(negedge clk);
        rd = io_rdata;
        io_sel = 1'b0; io_wr = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(16'hA000 + i * 37);
    endfunction

    initial begin
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rdata after reset", io_rdata, '0);
        access(2'd2, 1'b0, '0, 1, rd);
        chk("R1 pointer after reset", rd, 16'd0);

        // fill every word, varied strobe lengths
        access(2'd0, 1'b1, 16'd0, 1, rd);
        for (int i = 0; i < DEPTH; i++) access(2'd1, 1'b1, pat(i), 1 + (i % 3), rd);
        access(2'd2, 1'b0, '0, 1, rd);
        chk("R6 pointer wrapped after full burst", rd, 16'd0);

        // upper wdata bits ignored by load
        access(2'd0, 1'b1, 16'hFF00 | 16'd62, 2, rd);
        access(2'd2, 1'b0, '0, 1, rd);
        chk("R2 pointer load", rd, 16'd62);

        access(2'd1, 1'b0, '0, 1, rd);
        chk("R4 read word 62", rd, pat(62));
        access(2'd1, 1'b0, '0, 3, rd);
        chk("R4 held read word 63", rd, pat(63));
        access(2'd2, 1'b0, '0, 1, rd);
        chk("R6 wrap 63 to 0", rd, 16'd0);
        access(2'd1, 1'b0, '0, 4, rd);
        chk("R4 read word 0", rd, pat(0));
        access(2'd2, 1'b0, '0, 2, rd);
        chk("R5 one step per long strobe", rd, 16'd1);

        // R3 overwrite and read back
        access(2'd0, 1'b1, 16'd10, 1, rd);
        access(2'd1, 1'b1, 16'h5A5A, 3, rd);
        access(2'd2, 1'b0, '0, 1, rd);
        chk("R5 write advances pointer", rd, 16'd11);
        access(2'd0, 1'b1, 16'd10, 1, rd);
        access(2'd1, 1'b0, '0, 1, rd);
        chk("R3 stored word", rd, 16'h5A5A);
        access(2'd1, 1'b0, '0, 1, rd);
        chk("R3 neighbour untouched", rd, pat(11));

        // R8 ignored accesses, pointer now 12
        access(2'd2, 1'b1, 16'd40, 2, rd);
        access(2'd0, 1'b0, '0, 1, rd);
        chk("R8 read of load port", rd, 16'd0);
        access(2'd3, 1'b1, 16'hDEAD, 1, rd);
        access(2'd3, 1'b0, '0, 2, rd);
        chk("R8 read of port 3", rd, 16'd0);
        access(2'd2, 1'b0, '0, 1, rd);
        chk("R8 pointer unchanged", rd, 16'd12);
        access(2'd1, 1'b0, '0, 1, rd);
        chk("R8 memory unchanged", rd, pat(12));

        @(negedge clk);
        chk("R9 idle output", io_rdata, '0);
        access(2'd2, 1'b0, '0, 1, rd);
        chk("R7 readback", rd, 16'd13);

        // reset mid-burst
        access(2'd0, 1'b1, 16'd33, 1, rd);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 rdata after reset", io_rdata, '0);
        access(2'd2, 1'b0, '0, 1, rd);
        chk("R1 pointer cleared", rd, 16'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule